// File: doc/BRIEF.md
# SPI Register Slave

This block lets an external host read and write a bank of 16-bit registers over a four-wire serial link in which the host is always the master. A transaction runs while the active-low select is held low. It is built from 8-bit bursts. The first burst is a command: a direction flag and a register address. Every later pair of bursts carries one data word, high byte first. A write commits only after its low byte has fully arrived. Longer transactions step through consecutive registers, and the address wraps at the top of the bank.

The serial inputs are brought into the system clock domain through a short synchronizer, and edges of the serial clock are detected there. The serial clock idles low. Input data is taken on its rising edge, and the returned bit changes after its falling edge (mode 0). Logic elsewhere on the chip sees a one-cycle write strobe with address and word. It can also read any register through a separate combinational read port. A power-mode enable input turns the block off. While it is off, the output pad is released and no serial activity has any effect.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every register reads 0x0000 on the core read port, the write strobe is low and the MISO output enable is low.
- R2: The MISO output enable is high only while the enable input is high and the select is low; otherwise the pad is released.
- R3: MOSI is taken MSB first on rising serial clock edges. MISO changes only after falling edges. During the command burst MISO carries 0.
- R4: In the command burst, bit 7 = 1 selects a read and 0 a write, bits 5:0 give the register address, and bit 6 has no effect.
- R5: A write commits after the low byte completes. The block gives a single-cycle strobe with the address and the word {high byte, low byte}, and the register takes that word.
- R6: A read returns the addressed register as the high byte in the first data burst and the low byte in the second, each MSB first.
- R7: If the select rises before a low byte completes, the partial word is dropped: no strobe, and the register keeps its value.
- R8: Each further pair of bursts moves to the next register, for reads and writes alike. The address wraps from 63 to 0.
- R9: Bit counting restarts at every falling edge of the select, so an earlier transaction cut off mid-burst does not shift the next one.
- R10: While the enable input is low no write happens. A transaction already under way when the enable returns is ignored until the select next falls.
- R11: The core read port shows the current content of the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Power-mode enable; low turns the block off |
| spi_sck_i | input | 1 | Serial clock from the host, idles low |
| spi_cs_n_i | input | 1 | Active-low transaction select |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host |
| spi_miso_oe_o | output | 1 | Pad drive enable for MISO; low means high-impedance |
| wr_stb_o | output | 1 | One-cycle strobe for a committed write |
| wr_addr_o | output | 6 | Address of the committed write |
| wr_data_o | output | 16 | Word of the committed write |
| core_raddr_i | input | 6 | Core-side read address |
| core_rdata_o | output | 16 | Core-side read data |

## Verification
The bench runs multi-word writes and reads that start at address 62 and so cross the wrap. A design that did not wrap, or that fetched the next register one word late, would return the wrong or stale words there. It raises the select after only a high byte and after a five-bit fragment. A design that committed partial words would show a stray strobe, and one that kept its bit count across transactions would misread the next command byte. It also restores the enable in the middle of a transaction whose later bytes look like a valid write to another register; a design without the restart rule would write that register. A command with bit 6 set must still reach its register.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;
    localparam int DEF_ADDR_W  = 6;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_SYNC    = 2;
    localparam int BURST_BITS  = 8;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_V;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame
    import spi_reg_slave_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_data,
    output logic              stb_o,
    output logic [ADDR_W-1:0] stb_addr_o,
    output logic [DATA_W-1:0] stb_data_o,
    output logic              miso_o,
    output logic              sck_fall_o,
    output logic [2:0]        bit_cnt_o
);
    localparam int BYTES = DATA_W / BURST_BITS;
    localparam int BI_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [BI_W-1:0]   LAST_B = BI_W'(BYTES - 1);
    localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic              armed;
        logic [2:0]        bit_cnt;
        logic              addr_done;
        logic [BI_W-1:0]   byte_idx;
        logic              is_rd;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        rx;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] tx;
        logic              miso;
        logic              stb;
        logic [ADDR_W-1:0] stb_addr;
        logic [DATA_W-1:0] stb_data;
    } st_t;

    st_t st_q, st_d;
    logic [7:0] rx_next;
    logic [DATA_W+7:0] word_ext;
    logic sck_rise, sck_fall, cs_fell;

    assign rx_next  = {st_q.rx[6:0], mosi_s};
    assign word_ext = {st_q.word, rx_next};
    assign sck_rise = sck_s & ~st_q.sck_prev;
    assign sck_fall = ~sck_s & st_q.sck_prev;
    assign cs_fell  = st_q.cs_prev & ~cs_s;
    assign fetch_addr = st_q.addr_done ? (st_q.addr + ONE_A) : rx_next[ADDR_W-1:0];

    always_comb begin
        st_d = st_q;
        st_d.stb = 1'b0;
        if (!en_i || cs_s) begin
            st_d = '0;
        end else if (!st_q.armed) begin
            // only a fresh select edge arms the engine
            st_d.armed = cs_fell;
        end else begin
            if (sck_rise) begin
                st_d.rx      = rx_next;
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    if (!st_q.addr_done) begin
                        st_d.addr_done = 1'b1;
                        st_d.is_rd     = rx_next[7];
                        st_d.addr      = rx_next[ADDR_W-1:0];
                        st_d.byte_idx  = '0;
                        st_d.word      = '0;
                        st_d.tx        = rx_next[7] ? fetch_data : '0;
                    end else begin
                        st_d.word = word_ext[DATA_W-1:0];
                        if (st_q.byte_idx == LAST_B) begin
                            st_d.byte_idx = '0;
                            st_d.addr     = st_q.addr + ONE_A;
                            st_d.tx       = st_q.is_rd ? fetch_data : '0;
                            if (!st_q.is_rd) begin
                                st_d.stb      = 1'b1;
                                st_d.stb_addr = st_q.addr;
                                st_d.stb_data = word_ext[DATA_W-1:0];
                            end
                        end else begin
                            st_d.byte_idx = st_q.byte_idx + 1'b1;
                        end
                    end
                end
            end
            if (sck_fall) begin
                st_d.miso = st_q.tx[DATA_W-1];
                st_d.tx   = {st_q.tx[DATA_W-2:0], 1'b0};
            end
        end
        st_d.cs_prev  = cs_s;
        st_d.sck_prev = sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o      = st_q.stb;
    assign stb_addr_o = st_q.stb_addr;
    assign stb_data_o = st_q.stb_data;
    assign miso_o     = st_q.miso;
    assign sck_fall_o = sck_fall;
    assign bit_cnt_o  = st_q.bit_cnt;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] ra_addr_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [ADDR_W-1:0] rb_addr_i,
    output logic [DATA_W-1:0] rb_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign ra_data_o = mem_q[ra_addr_i];
    assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_slave_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int SYNC_N = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              spi_sck_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic [ADDR_W-1:0] core_raddr_i,
    output logic [DATA_W-1:0] core_rdata_o
);
    logic [2:0]        pins_s;
    logic              sck_s, cs_s, mosi_s;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] fetch_data;
    logic              miso_bit, sck_fall;
    logic [2:0]        bit_cnt;

    spi_reg_sync #(.W(3), .STAGES(SYNC_N), .RST_V(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({spi_sck_i, spi_cs_n_i, spi_mosi_i}),
        .sync_o(pins_s)
    );
    assign {sck_s, cs_s, mosi_s} = pins_s;

    spi_reg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .stb_o(wr_stb_o), .stb_addr_o(wr_addr_o), .stb_data_o(wr_data_o),
        .miso_o(miso_bit), .sck_fall_o(sck_fall), .bit_cnt_o(bit_cnt)
    );

    spi_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(wr_stb_o), .waddr_i(wr_addr_o), .wdata_i(wr_data_o),
        .ra_addr_i(fetch_addr), .ra_data_o(fetch_data),
        .rb_addr_i(core_raddr_i), .rb_data_o(core_rdata_o)
    );

    assign spi_miso_o    = miso_bit;
    assign spi_miso_oe_o = en_i & ~spi_cs_n_i;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       cs_s,
    input logic       sck_fall,
    input logic       miso_bit,
    input logic [2:0] bit_cnt,
    input logic       wr_stb_o
);
    // R10
    strb_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(en_i));
    // R5
    strb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);
    // R7
    strb_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> $past(!cs_s));
    // R3
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_s && en_i) |=> $stable(miso_bit));
    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (bit_cnt == 3'd0));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .cs_s(cs_s),
    .sck_fall(sck_fall), .miso_bit(miso_bit), .bit_cnt(bit_cnt),
    .wr_stb_o(wr_stb_o)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
    localparam int HP = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, wr_stb;
    logic [5:0]  wr_addr, core_raddr = '0;
    logic [15:0] wr_data, core_rdata;

    int n_checks = 0, n_errs = 0;
    bit done = 0;
    logic [15:0] ref_mem [64];
    logic [21:0] exp_q [$];

    always #2.5 clk = ~clk;

    spi_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en),
        .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
        .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .core_raddr_i(core_raddr), .core_rdata_o(core_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the next queued write
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(0, "R7 unexpected strobe", {10'd0, wr_addr, wr_data}, 32'h0);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R5 strobe addr/data", {10'd0, wr_addr, wr_data}, {10'd0, e});
            end
        end
    end

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            #(HP);
            rx[i] = miso;
            sck = 1'b1;
            #(HP);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        #(HP);
    endtask

    task automatic cs_hi();
        #(HP);
        cs_n = 1'b1;
        #(4*HP);
    endtask

    function automatic logic [15:0] pat(input logic [15:0] seed, input int k);
        return seed ^ 16'(k * 16'h1357);
    endfunction

    // driver: writes n words starting at addr, queueing the expected strobes
    task automatic do_write(input logic [5:0] addr, input int n, input logic [15:0] seed, input logic b6);
        logic [7:0] rx;
        cs_lo();
        xbyte({1'b0, b6, addr}, rx);
        for (int k = 0; k < n; k++) begin
            logic [5:0]  a;
            logic [15:0] w;
            a = addr + 6'(k);
            w = pat(seed, k);
            exp_q.push_back({a, w});
            ref_mem[a] = w;
            xbyte(w[15:8], rx);
            xbyte(w[7:0], rx);
        end
        cs_hi();
    endtask

    task automatic do_read(input logic [5:0] addr, input int n, input string req);
        logic [7:0] rx, hi, lo;
        cs_lo();
        check(miso_oe === 1'b1, "R2 oe while selected", {31'd0, miso_oe}, 32'd1);
        xbyte({2'b10, addr}, rx);
        check(rx == 8'h00, "R3 MISO zero in command burst", {24'd0, rx}, 32'd0);
        for (int k = 0; k < n; k++) begin
            logic [5:0] a;
            a = addr + 6'(k);
            xbyte(8'hFF, hi);
            xbyte(8'h00, lo);
            check({hi, lo} == ref_mem[a], req, {16'd0, hi, lo}, {16'd0, ref_mem[a]});
        end
        cs_hi();
    endtask

    task automatic core_chk(input logic [5:0] a, input string req);
        core_raddr = a;
        #1;
        check(core_rdata == ref_mem[a], req, {16'd0, core_rdata}, {16'd0, ref_mem[a]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        #(20);
        rst_n = 1'b1;
        #(HP);

        // R1 reset state
        check(miso_oe == 1'b0, "R1 oe low", {31'd0, miso_oe}, 32'd0);
        check(wr_stb == 1'b0, "R1 strobe low", {31'd0, wr_stb}, 32'd0);
        core_chk(6'd0, "R1 reg0 zero");
        core_chk(6'd63, "R1 reg63 zero");

        // R5 R11 single write, R6 read back
        do_write(6'd5, 1, 16'hA5C3, 1'b0);
        core_chk(6'd5, "R5 R11 reg5 written");
        do_read(6'd5, 1, "R6 read reg5");

        // R8 burst write crossing the wrap, then burst read
        do_write(6'd62, 4, 16'h3C96, 1'b0);
        core_chk(6'd62, "R8 reg62");
        core_chk(6'd63, "R8 reg63");
        core_chk(6'd0, "R8 reg0 after wrap");
        core_chk(6'd1, "R8 reg1 after wrap");
        do_read(6'd62, 4, "R8 burst read");

        // R4 bit 6 set still targets bits 5:0
        do_write(6'd7, 1, 16'h0F1E, 1'b1);
        core_chk(6'd7, "R4 bit6 ignored");
        core_chk(6'd39, "R4 no alias write");

        // R7 select rises after high byte only
        cs_lo();
        xbyte(8'h09, rx);
        xbyte(8'hDE, rx);
        cs_hi();
        core_chk(6'd9, "R7 partial word dropped");

        // R9 five-bit fragment then a clean write
        cs_lo();
        for (int i = 0; i < 5; i++) begin
            mosi = 1'b1; #(HP); sck = 1'b1; #(HP); sck = 1'b0;
        end
        cs_hi();
        do_write(6'd20, 1, 16'h1234, 1'b0);
        core_chk(6'd20, "R9 aligned after fragment");
        core_chk(6'd63, "R9 no stray write");

        // R2 R10 disabled during a full write
        en = 1'b0;
        cs_lo();
        check(miso_oe === 1'b0, "R2 oe low when disabled", {31'd0, miso_oe}, 32'd0);
        xbyte(8'h0C, rx);
        xbyte(8'hBE, rx);
        xbyte(8'hEF, rx);
        cs_hi();
        core_chk(6'd12, "R10 no write while disabled");

        // R10 enable returns mid transaction; later bytes mimic a write to 11
        cs_lo();
        xbyte(8'h0A, rx);
        en = 1'b1;
        xbyte(8'h0B, rx);
        xbyte(8'h55, rx);
        xbyte(8'h66, rx);
        cs_hi();
        core_chk(6'd10, "R10 reg10 untouched");
        core_chk(6'd11, "R10 reg11 untouched");

        check(miso_oe === 1'b0, "R2 oe low when deselected", {31'd0, miso_oe}, 32'd0);
        check(exp_q.size() == 0, "R5 all writes committed", exp_q.size(), 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule